// File: doc/BRIEF.md
# Transactional Line Cache with Conflict Tracking

A small direct-mapped data cache for one local core that can run a single hardware transaction at a time. While a transaction is open, stores are held in the cache as speculative data. Loads and stores mark the line they touch with a per-line read flag or write flag. Remote agents probe the cache through a snoop port. Each probe is compared against those flags in the same cycle to decide whether it breaks the isolation of the open transaction.

A conflict, an explicit abort request, or a miss that would have to evict a tracked line ends the transaction. Speculatively written lines are dropped and every flag is cleared in one cycle. A one-cycle abort pulse then reports the cause. A commit turns the speculative lines into ordinary dirty lines and clears the flags. When no transaction is open, the block behaves as a plain write-back cache with a simple line fill port and a fire-and-forget write-back port. Software drives begin, commit and abort, and retries aborted work itself.

Top module: `tx_line_cache`

## Requirements
- R1: After reset no transaction is open, `abort_pulse` is low and every line is invalid, so the first access to any address issues a fill request.
- R2: A core access is accepted (`core_ready` high while `core_valid` is high) only on a hit. A miss raises `mem_req_valid` for exactly one cycle with the line address. A read returns the word at word offset `core_addr[0]`. Evicting a dirty line emits it on the write-back port.
- R3: A store made inside a transaction is never written back and never supplied to a snoop before commit: `snp_supply` stays low for a line whose write flag is set.
- R4: While a transaction is open, a snoop hit is a conflict when it is a remote write and the line has either flag set, or when it is a remote read and the line has its write flag set. A remote read of a line with only the read flag set is a hit without a conflict.
- R5: Conflicts are judged per line, so a snoop to a line the transaction touched conflicts even if the remote agent aims at a word the transaction never used.
- R6: On abort, every line with its write flag set becomes invalid and all flags clear. Data that was dirty before the transaction is written back at the first transactional store to that line, so reads after the abort return the values from before the transaction.
- R7: On commit with no abort in the same cycle, speculative lines become dirty, all flags clear, the transaction closes, and a later remote read is supplied the committed data.
- R8: Every abort raises `abort_pulse` for exactly one cycle, in the cycle after the event, with `abort_cause` 0 for a remote read, 1 for a remote write, 2 for an explicit abort and 3 for a capacity overflow. A snoop cause beats explicit, and explicit beats capacity.
- R9: A transactional miss whose victim line holds a read or write flag aborts with cause 3 and issues no fill in that cycle. The access then completes as a non-transactional one.
- R10: With no transaction open, snoops never conflict. A remote write hit invalidates the line, and a remote read hit on a dirty line supplies it and leaves the line clean.
- R11: In any cycle with `snp_valid`, `tx_begin`, `tx_commit` or `tx_abort` high, the core port is stalled (`core_ready` low).
- R12: `tx_begin` with a transaction already open has no effect. `tx_commit` and `tx_abort` with no transaction open have no effect and raise no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_begin | input | 1 | Open a transaction |
| tx_commit | input | 1 | Commit the open transaction |
| tx_abort | input | 1 | Abort the open transaction |
| tx_active | output | 1 | A transaction is open |
| core_valid | input | 1 | Core request present |
| core_ready | output | 1 | Core request accepted this cycle |
| core_we | input | 1 | Request is a store |
| core_addr | input | ADDR_W | Word address |
| core_wdata | input | DATA_W | Store data |
| core_rdata | output | DATA_W | Load data, valid with `core_ready` |
| mem_req_valid | output | 1 | Line fill request |
| mem_req_addr | output | ADDR_W-1 | Line address to fill |
| mem_fill_valid | input | 1 | Fill data present |
| mem_fill_data | input | DATA_W*WORDS | Fill line, word 0 in the low bits |
| wb_valid | output | 1 | Line write-back |
| wb_addr | output | ADDR_W-1 | Write-back line address |
| wb_data | output | DATA_W*WORDS | Write-back line |
| snp_valid | input | 1 | Snoop present |
| snp_write | input | 1 | Snoop is a remote write (else remote read) |
| snp_addr | input | ADDR_W-1 | Snooped line address |
| snp_hit | output | 1 | Snooped line is resident |
| snp_conflict | output | 1 | Snoop conflicts with the open transaction |
| snp_supply | output | 1 | Dirty, non-speculative data returned |
| snp_data | output | DATA_W*WORDS | Supplied line |
| abort_pulse | output | 1 | One-cycle abort indication |
| abort_cause | output | 2 | Abort cause code |

## Verification
A flag left set or cleared by mistake shows up at the snoop port in the same cycle as the next probe of that line, as a missing or spurious `snp_conflict`. A speculative line that survives an abort shows up on the next core read of that address as a returned value from inside the transaction instead of a refetch of the old one. A lost pre-transaction write-back is exposed as stale data a few cycles after an abort, once the refetch completes. Cause codes and pulse width are observed one cycle after each abort event, and fill and write-back counts reveal whether a capacity abort wrongly started a fill.

// File: rtl/tlc_pkg.sv
package tlc_pkg;

    typedef enum logic [1:0] {
        CAUSE_RRD  = 2'd0,
        CAUSE_RWR  = 2'd1,
        CAUSE_EXPL = 2'd2,
        CAUSE_CAP  = 2'd3
    } abort_cause_e;

    typedef enum logic {
        FSM_IDLE = 1'b0,
        FSM_FILL = 1'b1
    } fill_fsm_e;

endpackage

// File: rtl/tlc_tag_match.sv
module tlc_tag_match #(
    parameter int LINES = 8,
    parameter int TAG_W = 12,
    parameter int IDX_W = 3
) (
    input  logic [LINES-1:0]            vld,
    input  logic [LINES-1:0][TAG_W-1:0] tags,
    input  logic [IDX_W-1:0]            idx,
    input  logic [TAG_W-1:0]            tag,
    output logic                        hit
);
    assign hit = vld[idx] && (tags[idx] == tag);
endmodule

// File: rtl/tlc_snoop_judge.sv
module tlc_snoop_judge (
    input  logic hit,
    input  logic is_write,
    input  logic rbit,
    input  logic wbit,
    input  logic dirty,
    input  logic tx_on,
    output logic conflict,
    output logic supply
);
    // Remote write clashes with anything tracked; remote read only with speculative data.
    assign conflict = tx_on && hit && (is_write ? (rbit || wbit) : wbit);
    // Only committed dirty data ever leaves the cache.
    assign supply   = hit && dirty && !wbit;
endmodule

// File: rtl/tlc_word_merge.sv
module tlc_word_merge #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 2,
    parameter int OFF_W  = 1
) (
    input  logic [DATA_W*WORDS-1:0] line_in,
    input  logic [OFF_W-1:0]        off,
    input  logic [DATA_W-1:0]       wdata,
    output logic [DATA_W*WORDS-1:0] line_out,
    output logic [DATA_W-1:0]       rd_word
);
    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign line_out[w*DATA_W +: DATA_W] =
            (off == OFF_W'(w)) ? wdata : line_in[w*DATA_W +: DATA_W];
    end

    always_comb begin
        rd_word = line_in[DATA_W-1:0];
        for (int w = 1; w < WORDS; w++) begin
            if (off == OFF_W'(w)) rd_word = line_in[w*DATA_W +: DATA_W];
        end
    end
endmodule

// File: rtl/tx_line_cache.sv
module tx_line_cache
    import tlc_pkg::*;
#(
    parameter int ADDR_W = 16,   // word address width
    parameter int DATA_W = 32,
    parameter int LINES  = 8,    // power of two
    parameter int WORDS  = 2     // words per line, power of two, at least 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tx_begin,
    input  logic                      tx_commit,
    input  logic                      tx_abort,
    output logic                      tx_active,
    input  logic                      core_valid,
    output logic                      core_ready,
    input  logic                      core_we,
    input  logic [ADDR_W-1:0]         core_addr,
    input  logic [DATA_W-1:0]         core_wdata,
    output logic [DATA_W-1:0]         core_rdata,
    output logic                      mem_req_valid,
    output logic [ADDR_W-$clog2(WORDS)-1:0] mem_req_addr,
    input  logic                      mem_fill_valid,
    input  logic [DATA_W*WORDS-1:0]   mem_fill_data,
    output logic                      wb_valid,
    output logic [ADDR_W-$clog2(WORDS)-1:0] wb_addr,
    output logic [DATA_W*WORDS-1:0]   wb_data,
    input  logic                      snp_valid,
    input  logic                      snp_write,
    input  logic [ADDR_W-$clog2(WORDS)-1:0] snp_addr,
    output logic                      snp_hit,
    output logic                      snp_conflict,
    output logic                      snp_supply,
    output logic [DATA_W*WORDS-1:0]   snp_data,
    output logic                      abort_pulse,
    output logic [1:0]                abort_cause
);
    localparam int OFF_W   = $clog2(WORDS);
    localparam int IDX_W   = $clog2(LINES);
    localparam int TAG_W   = ADDR_W - IDX_W - OFF_W;
    localparam int LINE_W  = DATA_W * WORDS;
    localparam int LADDR_W = ADDR_W - OFF_W;

    typedef struct packed {
        logic [LINES-1:0]             vld;
        logic [LINES-1:0]             dirty;
        logic [LINES-1:0]             rd;
        logic [LINES-1:0]             wr;
        logic [LINES-1:0][TAG_W-1:0]  tag;
        logic [LINES-1:0][LINE_W-1:0] data;
        logic                         tx_on;
        fill_fsm_e                    fsm;
        logic [LADDR_W-1:0]           fill_addr;
        logic                         pulse;
        abort_cause_e                 cause;
    } state_t;

    state_t q, d;

    // Address fields
    logic [OFF_W-1:0] c_off;
    logic [IDX_W-1:0] c_idx, s_idx, f_idx;
    logic [TAG_W-1:0] c_tag, s_tag, f_tag;

    assign c_off = core_addr[OFF_W-1:0];
    assign c_idx = core_addr[OFF_W +: IDX_W];
    assign c_tag = core_addr[ADDR_W-1 -: TAG_W];
    assign s_idx = snp_addr[IDX_W-1:0];
    assign s_tag = snp_addr[LADDR_W-1 -: TAG_W];
    assign f_idx = q.fill_addr[IDX_W-1:0];
    assign f_tag = q.fill_addr[LADDR_W-1 -: TAG_W];

    // Lookup
    logic c_hit, s_match;

    tlc_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_core_match (
        .vld (q.vld), .tags(q.tag), .idx(c_idx), .tag(c_tag), .hit(c_hit)
    );

    tlc_tag_match #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_snoop_match (
        .vld (q.vld), .tags(q.tag), .idx(s_idx), .tag(s_tag), .hit(s_match)
    );

    assign snp_hit = snp_valid && s_match;

    tlc_snoop_judge u_judge (
        .hit     (snp_hit),
        .is_write(snp_write),
        .rbit    (q.rd[s_idx]),
        .wbit    (q.wr[s_idx]),
        .dirty   (q.dirty[s_idx]),
        .tx_on   (q.tx_on),
        .conflict(snp_conflict),
        .supply  (snp_supply)
    );

    assign snp_data = snp_supply ? q.data[s_idx] : '0;

    logic [LINE_W-1:0] merged_line;
    logic [DATA_W-1:0] sel_word;

    tlc_word_merge #(.DATA_W(DATA_W), .WORDS(WORDS), .OFF_W(OFF_W)) u_merge (
        .line_in (q.data[c_idx]),
        .off     (c_off),
        .wdata   (core_wdata),
        .line_out(merged_line),
        .rd_word (sel_word)
    );

    // Core-side control
    logic ctl_busy, can_look, miss, cap_hit, abort_now, tx_save, evict_save;

    assign ctl_busy   = snp_valid || tx_begin || tx_commit || tx_abort;
    assign can_look   = core_valid && !ctl_busy && (q.fsm == FSM_IDLE);
    assign core_ready = can_look && c_hit;
    assign miss       = can_look && !c_hit;
    assign cap_hit    = miss && q.tx_on && (q.rd[c_idx] || q.wr[c_idx]);
    assign abort_now  = q.tx_on && (snp_conflict || tx_abort || cap_hit);

    // Save pre-transaction dirty data before the first speculative store overwrites it.
    assign tx_save    = core_ready && core_we && q.tx_on && q.dirty[c_idx] && !q.wr[c_idx];
    assign evict_save = miss && !abort_now && q.vld[c_idx] && q.dirty[c_idx];

    assign wb_valid      = tx_save || evict_save;
    assign wb_addr       = {q.tag[c_idx], c_idx};
    assign wb_data       = q.data[c_idx];
    assign mem_req_valid = miss && !abort_now;
    assign mem_req_addr  = core_addr[ADDR_W-1:OFF_W];
    assign core_rdata    = core_ready ? sel_word : '0;

    assign tx_active   = q.tx_on;
    assign abort_pulse = q.pulse;
    assign abort_cause = q.cause;

    always_comb begin
        d       = q;
        d.pulse = 1'b0;

        if (core_ready) begin
            if (core_we) begin
                d.data[c_idx] = merged_line;
                if (q.tx_on) begin
                    d.wr[c_idx]    = 1'b1;
                    d.dirty[c_idx] = 1'b0;
                end else begin
                    d.dirty[c_idx] = 1'b1;
                end
            end else if (q.tx_on) begin
                d.rd[c_idx] = 1'b1;
            end
        end

        if (mem_req_valid) begin
            d.vld[c_idx]   = 1'b0;
            d.dirty[c_idx] = 1'b0;
            d.fsm          = FSM_FILL;
            d.fill_addr    = mem_req_addr;
        end

        if (q.fsm == FSM_FILL && mem_fill_valid) begin
            d.vld[f_idx]   = 1'b1;
            d.dirty[f_idx] = 1'b0;
            d.rd[f_idx]    = 1'b0;
            d.wr[f_idx]    = 1'b0;
            d.tag[f_idx]   = f_tag;
            d.data[f_idx]  = mem_fill_data;
            d.fsm          = FSM_IDLE;
        end

        if (snp_hit) begin
            if (snp_write) begin
                d.vld[s_idx]   = 1'b0;
                d.dirty[s_idx] = 1'b0;
            end else if (snp_supply) begin
                d.dirty[s_idx] = 1'b0;
            end
        end

        if (abort_now) begin
            for (int i = 0; i < LINES; i++) begin
                if (q.wr[i]) begin
                    d.vld[i]   = 1'b0;
                    d.dirty[i] = 1'b0;
                end
            end
            d.rd    = '0;
            d.wr    = '0;
            d.tx_on = 1'b0;
            d.pulse = 1'b1;
            d.cause = snp_conflict ? (snp_write ? CAUSE_RWR : CAUSE_RRD)
                                   : (tx_abort ? CAUSE_EXPL : CAUSE_CAP);
        end else if (q.tx_on && tx_commit) begin
            d.dirty = d.dirty | q.wr;
            d.rd    = '0;
            d.wr    = '0;
            d.tx_on = 1'b0;
        end else if (!q.tx_on && tx_begin) begin
            d.tx_on = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/tlc_checker.sv
module tlc_checker (
    input logic clk,
    input logic rst_n,
    input logic tx_active,
    input logic tx_begin,
    input logic tx_commit,
    input logic tx_abort,
    input logic core_valid,
    input logic core_ready,
    input logic mem_req_valid,
    input logic snp_valid,
    input logic snp_hit,
    input logic snp_conflict,
    input logic abort_pulse
);
    p_req_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    p_ready_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> core_valid);

    p_conflict_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        snp_conflict |=> abort_pulse);

    p_commit_closes_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_active && tx_commit && !tx_abort && !snp_conflict) |=> (!tx_active && !abort_pulse));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    p_pulse_closes_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse |-> !tx_active);

    p_conflict_in_tx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        snp_conflict |-> (snp_hit && tx_active));

    p_snoop_stalls_r11: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !core_ready);

    p_begin_opens_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_active && tx_begin) |=> tx_active);
endmodule

bind tx_line_cache tlc_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tx_active    (tx_active),
    .tx_begin     (tx_begin),
    .tx_commit    (tx_commit),
    .tx_abort     (tx_abort),
    .core_valid   (core_valid),
    .core_ready   (core_ready),
    .mem_req_valid(mem_req_valid),
    .snp_valid    (snp_valid),
    .snp_hit      (snp_hit),
    .snp_conflict (snp_conflict),
    .abort_pulse  (abort_pulse)
);

// File: tb/tx_line_cache_tb.sv
module tx_line_cache_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tx_begin = 0, tx_commit = 0, tx_abort = 0;
    logic        tx_active;
    logic        core_valid = 0, core_we = 0;
    logic        core_ready;
    logic [15:0] core_addr = '0;
    logic [31:0] core_wdata = '0, core_rdata;
    logic        mem_req_valid;
    logic [14:0] mem_req_addr;
    logic        mem_fill_valid = 0;
    logic [63:0] mem_fill_data = '0;
    logic        wb_valid;
    logic [14:0] wb_addr;
    logic [63:0] wb_data;
    logic        snp_valid = 0, snp_write = 0;
    logic [14:0] snp_addr = '0;
    logic        snp_hit, snp_conflict, snp_supply;
    logic [63:0] snp_data;
    logic        abort_pulse;
    logic [1:0]  abort_cause;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_line_cache dut_i (.*);

    int tests = 0, fails = 0;
    int req_cnt = 0, wb_cnt = 0, pulse_cnt = 0;
    logic [1:0]  last_cause = '0;
    logic [63:0] last_wb = '0;
    logic [63:0] mem_line [int];
    logic [31:0] ref_w [int];
    logic [31:0] spec_w [int];

    function automatic logic [31:0] init_word(input int a);
        return 32'hC0DE0000 ^ (a * 32'h9E37);
    endfunction
    function automatic logic [63:0] get_line(input int l);
        if (mem_line.exists(l)) return mem_line[l];
        return {init_word(2*l+1), init_word(2*l)};
    endfunction
    function automatic logic [31:0] ref_word(input int a);
        if (ref_w.exists(a)) return ref_w[a];
        return init_word(a);
    endfunction
    function automatic logic [31:0] tx_word(input int a);
        if (spec_w.exists(a)) return spec_w[a];
        return ref_word(a);
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    // Memory, write-back and abort observer: samples late in each cycle.
    int fill_cnt = 0;
    int pend = 0;
    initial begin
        forever begin
            @(negedge clk); #3;
            if (wb_valid) begin
                mem_line[int'(wb_addr)] = wb_data;
                wb_cnt++;
                last_wb = wb_data;
            end
            if (abort_pulse) begin
                pulse_cnt++;
                last_cause = abort_cause;
            end
            mem_fill_valid = 1'b0;
            if (fill_cnt > 0) begin
                fill_cnt--;
                if (fill_cnt == 0) begin
                    mem_fill_valid = 1'b1;
                    mem_fill_data  = get_line(pend);
                end
            end
            if (mem_req_valid) begin
                req_cnt++;
                pend = int'(mem_req_addr);
                fill_cnt = 2;
            end
        end
    end

    task automatic access(input logic we, input int a, input logic [31:0] wd, output logic [31:0] rd);
        bit done;
        @(negedge clk);
        core_valid = 1'b1; core_we = we; core_addr = 16'(a); core_wdata = wd;
        done = 0;
        rd = '0;
        while (!done) begin
            #4;
            if (core_ready) begin rd = core_rdata; done = 1; end
            else @(negedge clk);
        end
        @(negedge clk);
        core_valid = 1'b0; core_we = 1'b0;
    endtask

    task automatic snoop(input logic wr, input int la, output logic hit, output logic conf,
                         output logic sup, output logic [63:0] data);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = wr; snp_addr = 15'(la);
        #4;
        hit = snp_hit; conf = snp_conflict; sup = snp_supply; data = snp_data;
        if (sup) mem_line[la] = snp_data;  // remote agent / memory absorbs supplied line
        @(negedge clk);
        snp_valid = 1'b0; snp_write = 1'b0;
    endtask

    task automatic ctl(input logic b, input logic c, input logic a);
        @(negedge clk);
        tx_begin = b; tx_commit = c; tx_abort = a;
        @(negedge clk);
        tx_begin = 0; tx_commit = 0; tx_abort = 0;
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #4;
    endtask

    localparam int A = 16;     // line 8: index 0, tag 1
    localparam int B = 0;      // line 0: index 0, tag 0
    localparam int LA = 8;

    initial begin
        logic [31:0] rd;
        logic hit, conf, sup;
        logic [63:0] sd;
        int r0, w0, p0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
        // R1 reset state
        chk("R1 tx_active after reset", tx_active, 0);
        chk("R1 abort_pulse after reset", abort_pulse, 0);
        chk("R1 core_ready idle", core_ready, 0);
        r0 = req_cnt;
        access(0, A, 0, rd);
        chk("R1 cold access fills", req_cnt - r0, 1);
        chk("R2 read fill data", rd, init_word(A));
        r0 = req_cnt;
        access(0, A, 0, rd);
        chk("R2 hit needs no fill", req_cnt - r0, 0);

        // R2 dirty eviction
        access(1, A, 32'h11111111, rd); ref_w[A] = 32'h11111111;
        w0 = wb_cnt;
        access(0, B, 0, rd);
        chk("R2 eviction write-back", wb_cnt - w0, 1);
        chk("R2 written-back word", last_wb[31:0], 32'h11111111);
        access(0, A, 0, rd);
        chk("R2 refetched value", rd, 32'h11111111);

        // R6 / R3 / R4 / R8: remote read of speculative line
        access(1, A+1, 32'h22222222, rd); ref_w[A+1] = 32'h22222222;
        ctl(1, 0, 0);
        chk("R12 begin opens", tx_active, 1);
        w0 = wb_cnt;
        access(1, A, 32'h33333333, rd);
        chk("R6 pre-tx dirty saved", wb_cnt - w0, 1);
        chk("R6 saved old word", last_wb[63:32], 32'h22222222);
        access(0, A, 0, rd);
        chk("R6 tx sees own store", rd, 32'h33333333);
        p0 = pulse_cnt;
        snoop(0, LA, hit, conf, sup, sd);
        chk("R4 remote read of written line conflicts", conf, 1);
        chk("R3 speculative data not supplied", sup, 0);
        settle();
        chk("R8 one pulse", pulse_cnt - p0, 1);
        chk("R8 cause remote read", last_cause, 0);
        chk("R8 tx closed", tx_active, 0);
        r0 = req_cnt;
        access(0, A, 0, rd);
        chk("R6 speculative line dropped", req_cnt - r0, 1);
        chk("R6 old word restored", rd, 32'h11111111);
        access(0, A+1, 0, rd);
        chk("R6 old dirty word restored", rd, 32'h22222222);

        // R5 false conflict on a remote write
        ctl(1, 0, 0);
        access(0, A, 0, rd);
        p0 = pulse_cnt;
        snoop(1, LA, hit, conf, sup, sd);
        chk("R5 line-granular conflict", conf, 1);
        settle();
        chk("R8 cause remote write", last_cause, 1);
        chk("R8 one pulse rw", pulse_cnt - p0, 1);

        // R4 read-only sharing, R7 commit
        ctl(1, 0, 0);
        access(0, A, 0, rd);
        chk("R6 value after abort", rd, 32'h11111111);
        p0 = pulse_cnt;
        snoop(0, LA, hit, conf, sup, sd);
        chk("R4 shared read hit", hit, 1);
        chk("R4 shared read no conflict", conf, 0);
        ctl(0, 1, 0);
        settle();
        chk("R7 commit closes", tx_active, 0);
        chk("R7 commit no pulse", pulse_cnt - p0, 0);

        // R7 visibility after commit, R3 no write-back of speculation
        ctl(1, 0, 0);
        w0 = wb_cnt;
        access(1, A, 32'h44444444, rd);
        chk("R3 no write-back of speculative store", wb_cnt - w0, 0);
        ctl(0, 1, 0);
        ref_w[A] = 32'h44444444;
        snoop(0, LA, hit, conf, sup, sd);
        chk("R7 committed data supplied", sup, 1);
        chk("R7 committed word", sd[31:0], 32'h44444444);
        chk("R7 no conflict after commit", conf, 0);

        // R12 ignored controls, R8 explicit abort
        p0 = pulse_cnt;
        ctl(0, 0, 1);
        settle();
        chk("R12 abort while idle ignored", pulse_cnt - p0, 0);
        ctl(0, 1, 0);
        chk("R12 commit while idle ignored", tx_active, 0);
        ctl(1, 0, 0);
        ctl(1, 0, 0);
        chk("R12 second begin keeps tx", tx_active, 1);
        access(1, A, 32'h55555555, rd);
        ctl(0, 0, 1);
        settle();
        chk("R8 cause explicit", last_cause, 2);
        chk("R8 explicit pulse", pulse_cnt - p0, 1);
        access(0, A, 0, rd);
        chk("R6 explicit abort drops store", rd, 32'h44444444);

        // R9 capacity overflow
        ctl(1, 0, 0);
        access(0, A, 0, rd);
        p0 = pulse_cnt;
        r0 = req_cnt;
        access(0, B, 0, rd);
        chk("R9 cause capacity", last_cause, 3);
        chk("R9 one pulse", pulse_cnt - p0, 1);
        chk("R9 single fill after abort", req_cnt - r0, 1);
        chk("R9 access completes", rd, ref_word(B));
        chk("R9 tx closed", tx_active, 0);

        // R10 snoops with no transaction
        access(1, A, 32'h66666666, rd); ref_w[A] = 32'h66666666;
        snoop(0, LA, hit, conf, sup, sd);
        chk("R10 dirty supplied", sup, 1);
        chk("R10 supplied word", sd[31:0], 32'h66666666);
        chk("R10 no conflict outside tx", conf, 0);
        snoop(1, LA, hit, conf, sup, sd);
        chk("R10 remote write hit", hit, 1);
        chk("R10 remote write no conflict", conf, 0);
        r0 = req_cnt;
        access(0, A, 0, rd);
        chk("R10 remote write invalidated", req_cnt - r0, 1);
        chk("R10 value via memory", rd, 32'h66666666);

        // R11 snoop stalls the core
        @(negedge clk);
        core_valid = 1; core_we = 0; core_addr = 16'(A);
        snp_valid = 1; snp_write = 0; snp_addr = 15'd3;
        #4;
        chk("R11 stalled during snoop", core_ready, 0);
        @(negedge clk);
        snp_valid = 0;
        #4;
        chk("R11 accepted after snoop", core_ready, 1);
        @(negedge clk);
        core_valid = 0;

        // Random mix: plain traffic and transactions
        begin
            int unused_seed;
            unused_seed = $urandom(32'd20240);
        end
        for (int round = 0; round < 40; round++) begin
            for (int k = 0; k < 10; k++) begin
                int a;
                logic [31:0] v;
                a = int'($urandom_range(63, 0));
                v = $urandom;
                if ($urandom_range(1, 0) == 1) begin
                    access(1, a, v, rd); ref_w[a] = v;
                end else begin
                    access(0, a, 0, rd);
                    chk("R2 random read", rd, ref_word(a));
                end
            end
            ctl(1, 0, 0);
            spec_w.delete();
            for (int k = 0; k < 6; k++) begin
                int a;
                logic [31:0] v;
                a = int'($urandom_range(15, 0));
                v = $urandom;
                if ($urandom_range(1, 0) == 1) begin
                    access(1, a, v, rd); spec_w[a] = v;
                end else begin
                    access(0, a, 0, rd);
                    chk("R6 random tx read", rd, tx_word(a));
                end
            end
            if ($urandom_range(1, 0) == 1) begin
                ctl(0, 1, 0);
                foreach (spec_w[i]) ref_w[i] = spec_w[i];
            end else begin
                ctl(0, 0, 1);
            end
            spec_w.delete();
            for (int a = 0; a < 16; a++) begin
                access(0, a, 0, rd);
                chk("R7 random after tx end", rd, ref_word(a));
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule